// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block looks after the housekeeping a 512-row asynchronous DRAM needs on its own. After reset it lets a power-up pause run out. It then runs a short series of warm-up refresh cycles. After that it spaces refresh cycles evenly, so that every row is visited once per refresh window. Each cycle is negotiated with the access controller: the sequencer raises `ref_req` and drives nothing on the memory pins until `ref_gnt` comes back.

A parameter selects the refresh mechanism. In counter-in-device mode (`USE_CBR=1`), CAS is taken low ahead of RAS and no address is driven. In external-row mode (`USE_CBR=0`), CAS stays high and a 9-bit row counter inside the block is placed on the address pins. All time limits are given in nanoseconds and turned into clock cycles from `CLK_NS`.

The request/grant pair is a valid/ready handshake. `ref_req` is the valid and `ref_gnt` is the ready. Once raised, `ref_req` is held until a cycle in which `ref_gnt` is sampled high. That cycle is the transfer, and `ref_req` drops on the next edge. A grant while `ref_req` is low has no effect. If grants arrive late, the missed intervals are counted up to `DEBT_MAX` and then repaid back to back.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is held and just after it, ras_n=1, cas_n=1, ref_req=0, addr_oe=0 and init_done=0.
- R2: ref_req rises no sooner than ceil(PAUSE_NS/CLK_NS) cycles and no later than two cycles beyond that after reset release.
- R3: Once raised, ref_req stays high until ref_gnt is sampled high. While no grant is given, RAS never falls.
- R4: Exactly WARMUP refresh cycles run before init_done rises. init_done is low at each of their RAS falls, rises with RAS high once the last warm-up precharge ends, and never falls afterwards.
- R5: With USE_CBR=1, cas_n is low in the cycle before RAS falls and for at least ceil(15 ns/CLK_NS) cycles of RAS low, and addr_oe stays 0.
- R6: With USE_CBR=0, cas_n stays 1, addr_oe is 1 in the cycle before RAS falls, and addr is stable for the whole RAS-low time.
- R7: RAS is low for at least ceil(RAS_LOW_NS/CLK_NS) cycles per refresh. Between cycles it is high for at least max(ceil(RAS_HIGH_NS/CLK_NS), ceil(CYCLE_NS/CLK_NS) minus the low time) cycles.
- R8: With USE_CBR=0, the row on addr starts at 0 after reset, rises by one for each refresh including warm-ups, and wraps from 511 to 0.
- R9: After init_done, one refresh is requested every floor(WINDOW_NS/ROWS/CLK_NS) cycles when grants come at once.
- R10: Owed refreshes saturate at DEBT_MAX. After a long grant stall, the catch-up burst holds DEBT_MAX cycles plus only those ticks that fall during the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | output | 1 | Refresh request (valid) |
| ref_gnt | input | 1 | Grant from access controller (ready) |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_oe | output | 1 | Address bus drive enable |
| addr | output | 9 | Row address (external-row mode) |
| init_done | output | 1 | High once warm-up has finished; access path blocked while low |

## Verification
Four properties are checked on every cycle: the request hold, init_done never falling, RAS low for at least its minimum width, and correct strobe and address conditions at each RAS fall, including a stable address while RAS is low. Other behaviours can only be shown by the bench's scenarios. These are the pause length, the exact warm-up count, the row sequence through its wrap, the refresh spacing and the debt cap after a stall.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_LEAD, ST_RAS, ST_PRE} rf_state_e;

  // round a time up to whole clocks, never below one
  function automatic int ns_up(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  // round a time down to whole clocks, never below one
  function automatic int ns_down(input int ns, input int clk_ns);
    int c;
    c = ns / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched #(
  parameter int T_PAUSE  = 20000,
  parameter int T_INT    = 1562,
  parameter int WARMUP   = 8,
  parameter int DEBT_MAX = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic want,
  output logic init_done
);
  localparam int PW = $clog2(T_PAUSE + 1);
  localparam int IW = $clog2(T_INT + 1);
  localparam int WW = $clog2(WARMUP + 1);
  localparam int DW = $clog2(DEBT_MAX + 1);

  logic [PW-1:0] pause_cnt;
  logic          pause_done;
  logic [WW-1:0] warm_left;
  logic [IW-1:0] int_cnt;
  logic [DW-1:0] debt;
  logic          tick;

  assign init_done = pause_done && (warm_left == '0);
  assign tick      = init_done && (int_cnt == IW'(T_INT - 1));
  assign want      = pause_done && ((warm_left != '0) || (debt != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_cnt  <= '0;
      pause_done <= 1'b0;
    end else if (!pause_done) begin
      if (pause_cnt == PW'(T_PAUSE - 1)) pause_done <= 1'b1;
      else                               pause_cnt  <= pause_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        warm_left <= WW'(WARMUP);
    else if (done && warm_left != '0)  warm_left <= warm_left - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !init_done) int_cnt <= '0;
    else if (tick)            int_cnt <= '0;
    else                      int_cnt <= int_cnt + 1'b1;
  end

  logic take;
  assign take = start && init_done && (debt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) debt <= '0;
    else if (tick && !take) begin
      if (debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
    end else if (take && !tick) debt <= debt - 1'b1;
  end
endmodule

// File: rtl/dram_rfsh_fsm.sv
module dram_rfsh_fsm
  import dram_rfsh_pkg::*;
#(
  parameter int T_LEAD  = 1,
  parameter int T_RAS   = 8,
  parameter int T_CHR   = 2,
  parameter int T_PRE   = 7,
  parameter bit USE_CBR = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ras_n,
  output logic cas_n,
  output logic addr_oe,
  output logic start,
  output logic row_adv,
  output logic done
);
  localparam int CW = $clog2(imax(imax(T_LEAD, T_RAS), T_PRE) + 1);

  rf_state_e     st;
  logic [CW-1:0] cnt;

  assign ref_req = (st == ST_REQ);
  assign start   = ref_req && ref_gnt;
  assign row_adv = (st == ST_RAS) && (cnt == CW'(T_RAS - 1));
  assign done    = (st == ST_PRE) && (cnt == CW'(T_PRE - 1));
  assign ras_n   = (st != ST_RAS);
  assign addr_oe = !USE_CBR && ((st == ST_LEAD) || (st == ST_RAS));

  generate
    if (USE_CBR) begin : g_cbr
      assign cas_n = !((st == ST_LEAD) || ((st == ST_RAS) && (cnt < CW'(T_CHR))));
    end else begin : g_rowonly
      assign cas_n = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (want) st <= ST_REQ;
        ST_REQ: if (ref_gnt) begin
          st  <= ST_LEAD;
          cnt <= '0;
        end
        ST_LEAD: begin
          if (cnt == CW'(T_LEAD - 1)) begin
            st  <= ST_RAS;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_RAS: begin
          if (row_adv) begin
            st  <= ST_PRE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_PRE: begin
          if (done) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_rfsh_rowctr.sv
module dram_rfsh_rowctr #(
  parameter int ROWS    = 512,
  parameter bit USE_CBR = 1'b0,
  localparam int RW     = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_adv,
  output logic [RW-1:0] row
);
  generate
    if (USE_CBR) begin : g_internal
      assign row = '0;
    end else begin : g_external
      logic [RW-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)                        r <= '0;
        else if (row_adv && r == RW'(ROWS - 1)) r <= '0;
        else if (row_adv)                  r <= r + 1'b1;
      end
      assign row = r;
    end
  endgenerate
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int PAUSE_NS    = 200000,
  parameter int WINDOW_NS   = 8000000,
  parameter int ROWS        = 512,
  parameter int WARMUP      = 8,
  parameter int DEBT_MAX    = 3,
  parameter int RAS_LOW_NS  = 80,
  parameter int RAS_HIGH_NS = 60,
  parameter int CYCLE_NS    = 150,
  parameter int CAS_LEAD_NS = 10,
  parameter int CAS_HOLD_NS = 15,
  parameter bit USE_CBR     = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       ref_req,
  input  logic       ref_gnt,
  output logic       ras_n,
  output logic       cas_n,
  output logic       addr_oe,
  output logic [8:0] addr,
  output logic       init_done
);
  localparam int RW      = $clog2(ROWS);
  localparam int T_PAUSE = ns_up(PAUSE_NS, CLK_NS);
  localparam int T_INT   = ns_down(WINDOW_NS / ROWS, CLK_NS);
  localparam int T_RAS   = ns_up(RAS_LOW_NS, CLK_NS);
  localparam int T_PRE   = imax(ns_up(RAS_HIGH_NS, CLK_NS), ns_up(CYCLE_NS, CLK_NS) - T_RAS);
  localparam int T_LEAD  = USE_CBR ? ns_up(CAS_LEAD_NS, CLK_NS) : 1;
  localparam int T_CHR   = ns_up(CAS_HOLD_NS, CLK_NS);

  logic want, start, row_adv, done;
  logic [RW-1:0] row;

  dram_rfsh_sched #(.T_PAUSE(T_PAUSE), .T_INT(T_INT), .WARMUP(WARMUP), .DEBT_MAX(DEBT_MAX)) u_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .want(want), .init_done(init_done));

  dram_rfsh_fsm #(.T_LEAD(T_LEAD), .T_RAS(T_RAS), .T_CHR(T_CHR), .T_PRE(T_PRE), .USE_CBR(USE_CBR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .want(want), .ref_gnt(ref_gnt), .ref_req(ref_req), .ras_n(ras_n),
    .cas_n(cas_n), .addr_oe(addr_oe), .start(start), .row_adv(row_adv), .done(done));

  dram_rfsh_rowctr #(.ROWS(ROWS), .USE_CBR(USE_CBR)) u_row (
    .clk(clk), .rst_n(rst_n), .row_adv(row_adv), .row(row));

  assign addr = addr_oe ? 9'(row) : 9'd0;
endmodule

// File: rtl/dram_rfsh_chk.sv
module dram_rfsh_chk
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter int RAS_LOW_NS = 80,
  parameter bit USE_CBR    = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_req,
  input logic       ref_gnt,
  input logic       ras_n,
  input logic       cas_n,
  input logic       addr_oe,
  input logic [8:0] addr,
  input logic       init_done
);
  localparam int MIN_LOW = ns_up(RAS_LOW_NS, CLK_NS);
  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || ras_n)       low_cnt <= '0;
    else if (low_cnt != '1)    low_cnt <= low_cnt + 1'b1;
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);

  // R4
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_cnt >= 16'(MIN_LOW)));

  // R5 R6
  strobe_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (USE_CBR ? (!$past(cas_n) && !addr_oe) : ($past(addr_oe) && cas_n)));

  // R6
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !$past(ras_n)) |-> $stable(addr));
endmodule

bind dram_rfsh_seq dram_rfsh_chk #(.CLK_NS(CLK_NS), .RAS_LOW_NS(RAS_LOW_NS), .USE_CBR(USE_CBR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt), .ras_n(ras_n), .cas_n(cas_n),
  .addr_oe(addr_oe), .addr(addr), .init_done(init_done));

// File: tb/sim_dram_rfsh_seq.sv
module sim_dram_rfsh_seq;
  localparam int CLK_NS = 10, PAUSE_NS = 2000, WIN_NS = 512000, ROWS = 512;
  localparam int WARM = 8, DEBT = 3;
  localparam int T_PAUSE = 200, T_RAS = 8, T_PRE = 7, T_CHR = 2;
  localparam int N_ROWS = 530;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req0, gnt0 = 1'b0, ras0, cas0, oe0, init0, hold0 = 1'b0;
  logic req1, gnt1 = 1'b0, ras1, cas1, oe1, init1, hold1 = 1'b0;
  logic [8:0] addr0, addr1;

  dram_rfsh_seq #(.CLK_NS(CLK_NS), .PAUSE_NS(PAUSE_NS), .WINDOW_NS(WIN_NS), .WARMUP(WARM),
    .DEBT_MAX(DEBT), .USE_CBR(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_req(req0), .ref_gnt(gnt0), .ras_n(ras0), .cas_n(cas0),
    .addr_oe(oe0), .addr(addr0), .init_done(init0));

  dram_rfsh_seq #(.CLK_NS(CLK_NS), .PAUSE_NS(PAUSE_NS), .WINDOW_NS(WIN_NS), .WARMUP(WARM),
    .DEBT_MAX(DEBT), .USE_CBR(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ref_req(req1), .ref_gnt(gnt1), .ras_n(ras1), .cas_n(cas1),
    .addr_oe(oe1), .addr(addr1), .init_done(init1));

  int checks = 0, errors = 0;
  int exp_q[$];
  int fall0 = 0, fall1 = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: expected row sequence for the external-row instance
  task automatic push_rows(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(i % ROWS);
  endtask

  // grant drivers: answer at once unless held off
  initial forever begin
    @(negedge clk);
    gnt0 = req0 && !hold0;
    gnt1 = req1 && !hold1;
  end

  // monitor for u0 (external row counter)
  initial begin
    logic p_ras = 1'b1, p_oe = 1'b0;
    int lo = 0, hi = 0, a_fall = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (p_ras && !ras0) begin
          fall0++;
          if (exp_q.size() == 0) chk(1'b0, "R8", int'(addr0), -1);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(addr0) == e, "R8", int'(addr0), e);
          end
          chk(cas0 == 1'b1 && p_oe == 1'b1, "R6", {cas0, p_oe}, 3);
          if (fall0 > 1) chk(hi >= T_PRE, "R7", hi, T_PRE);
          if (fall0 <= WARM) chk(init0 == 1'b0, "R4", init0, 0);
          a_fall = int'(addr0);
          hi = 0;
        end
        if (!ras0) begin
          lo++;
          if (int'(addr0) != a_fall || !cas0) chk(1'b0, "R6", int'(addr0), a_fall);
        end else hi++;
        if (!p_ras && ras0) begin
          chk(lo >= T_RAS, "R7", lo, T_RAS);
          lo = 0;
        end
      end
      p_ras = ras0;
      p_oe  = oe0;
    end
  end

  // monitor for u1 (counter inside the device)
  initial begin
    logic p_ras = 1'b1;
    int lead = 0, clow = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (p_ras && !ras1) begin
          fall1++;
          chk(lead >= 1 && !oe1, "R5", lead, 1);
          if (fall1 <= WARM) chk(init1 == 1'b0, "R4", init1, 0);
          clow = 0;
        end
        if (ras1) lead = cas1 ? 0 : lead + 1;
        else if (!cas1) clow++;
        if (!p_ras && ras1) chk(clow >= T_CHR, "R5", clow, T_CHR);
      end
      p_ras = ras1;
    end
  end

  initial begin
    push_rows(N_ROWS);
    repeat (5) @(negedge clk);
    chk(ras0 && cas0 && !req0 && !oe0 && !init0, "R1", {ras0, cas0, req0, oe0, init0}, 5'b11000);
    chk(ras1 && cas1 && !req1 && !oe1 && !init1, "R1", {ras1, cas1, req1, oe1, init1}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras0 && cas0 && !req0 && !init0, "R1", {ras0, cas0, req0, init0}, 4'b1100);
    fork
      begin : path_u0
        int cyc = 1;
        while (!req0 && cyc < 1000) begin @(negedge clk); cyc++; end
        chk(cyc >= T_PAUSE && cyc <= T_PAUSE + 2, "R2", cyc, T_PAUSE);
        while (fall0 < N_ROWS) @(negedge clk);
      end
      begin : path_u1
        int s, f;
        while (!init1) @(negedge clk);
        chk(fall1 == WARM && ras1, "R4", fall1, WARM);
        s = fall1;
        repeat (1000) @(negedge clk);
        chk(fall1 - s >= 9 && fall1 - s <= 10, "R9", fall1 - s, 9);
        chk(init1 == 1'b1, "R4", init1, 1);
        hold1 = 1'b1;
        repeat (30) @(negedge clk);
        f = fall1;
        repeat (670) @(negedge clk);
        chk(fall1 == f, "R3", fall1 - f, 0);
        chk(req1 == 1'b1, "R3", req1, 1);
        hold1 = 1'b0;
        s = fall1;
        repeat (130) @(negedge clk);
        chk(fall1 - s >= DEBT && fall1 - s <= DEBT + 2, "R10", fall1 - s, DEBT);
      end
    join
    chk(exp_q.size() == N_ROWS - fall0, "R8", exp_q.size(), N_ROWS - fall0);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule